// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block lets a coprocessor follow the instruction stream of a host CPU that prefetches code. It watches the host bus for instruction fetch words and keeps a six-byte copy of the host's instruction queue. It also samples the host's two-bit queue status code on every clock, which says whether a byte left the queue and what kind of byte it was.

When the host takes the first byte of an instruction, the tracker checks that byte for the escape pattern. If the pattern matches, it waits for the next queue byte and then emits a one-cycle pulse. The pulse carries an 11-bit external opcode. Escape bytes that were prefetched but are thrown away by a flush are never reported.

The fetch side is a monitor of a bus that cannot be stalled. `fetch_ready` says whether a fetch word presented in the current cycle would fit, after any removal or flush in the same cycle. The host does not see `fetch_ready`, so there is no back-pressure. A fetch word presented while `fetch_ready` is low is dropped and recorded as an overflow. The escape output is a valid-only stream with no ready input, and the consumer must accept each pulse.

Top module: `sq_queue_tracker`

## Requirements
- R1: After reset, `q_level` is 0, `esc_valid` is 0, `ovf_err` and `unf_err` are 0, and `fetch_ready` is 1 while the inputs are idle.
- R2: A fetch is a cycle with `bus_dv`=1 and `bus_stat`=3'b100. It appends `bus_ad[7:0]` and then `bus_ad[15:8]` to the tail, so `q_level` rises by 2 one cycle later. A cycle with `bus_dv`=1 and any other `bus_stat` value leaves `q_level` unchanged.
- R3: `qstat`=2'b00 removes nothing and leaves `q_level` unchanged.
- R4: `qstat`=2'b01 removes the head byte as an instruction's first byte.
  - If bits [7:3] of that byte equal 5'b11011, an escape is armed.
  - Otherwise the byte is discarded and no pulse follows.
- R5: `qstat`=2'b11 removes the head byte.
  - If an escape is armed, `esc_valid` is 1 for exactly one cycle, starting one cycle after the removal. `esc_opcode` then equals {escape byte[2:0], removed byte}, and the escape is disarmed.
  - If no escape is armed, the byte is dropped with no pulse.
- R6: `qstat`=2'b10 empties the queue and cancels an armed escape. A fetch in the same cycle is stored into the emptied queue, leaving `q_level` at 2.
- R7: When a removal and a fetch fall in the same cycle, the removal is applied first. The fetch is accepted if two bytes of room exist after the removal, and `fetch_ready` reflects this.
- R8: A fetch without room for two bytes is dropped whole and leaves `q_level` unchanged. It sets `ovf_err`, which stays 1 until reset.
- R9: A removal code (2'b01 or 2'b11) while the queue is empty removes nothing and gives no pulse. It sets `unf_err`, which stays 1 until reset.
- R10: `q_level` never exceeds the depth, 6 bytes by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stat | input | 3 | Host bus cycle status; 3'b100 marks a code fetch |
| bus_ad | input | 16 | Host address/data bus, read while `bus_dv` is 1 |
| bus_dv | input | 1 | Data phase of a host bus cycle |
| qstat | input | 2 | Host queue status code |
| fetch_ready | output | 1 | A fetch this cycle would be stored |
| esc_valid | output | 1 | One-cycle escape report |
| esc_opcode | output | 11 | External opcode carried with `esc_valid` |
| q_level | output | 3 | Bytes held in the shadow queue |
| ovf_err | output | 1 | Sticky: a fetch was dropped |
| unf_err | output | 1 | Sticky: a removal hit an empty queue |

## Verification
A byte removal and a fetch push can fall in the same cycle. This is the case where the order of operations decides whether a nearly full queue accepts the word. The bench brings the queue to five bytes and then presents a first-byte removal together with a fetch. Because the removal is applied first, it expects the word to be accepted and the level to read six. A flush presented together with a fetch is judged the same way: the level must read two.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  localparam logic [4:0] ESC_TAG = 5'b11011;
endpackage

// File: rtl/sq_shadow_queue.sv
module sq_shadow_queue #(
  parameter int DEPTH = 6,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          flush,
  input  logic          push,
  input  logic [15:0]   push_word,
  output logic [7:0]    head,
  output logic [LW-1:0] level,
  output logic          taken,
  output logic          room,
  output logic          push_drop,
  output logic          pop_under
);
  logic [7:0]    mem   [DEPTH];
  logic [7:0]    mem_n [DEPTH];
  logic [LW-1:0] base;
  logic          push_ok;

  // Removal is resolved first; the push then lands behind what is left.
  always_comb begin
    taken     = pop && (level != '0) && !flush;
    pop_under = pop && (level == '0);
    base      = flush ? '0 : (level - LW'(taken));
    room      = (LW'(DEPTH) - base) >= LW'(2);
    push_ok   = push && room;
    push_drop = push && !room;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_comb begin
        if (taken) mem_n[i] = (i < DEPTH - 1) ? mem[(i + 1) % DEPTH] : 8'h00;
        else       mem_n[i] = mem[i];
        if (push_ok && (i == int'(base)))     mem_n[i] = push_word[7:0];
        if (push_ok && (i == int'(base) + 1)) mem_n[i] = push_word[15:8];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) mem[i] <= 8'h00;
        else        mem[i] <= mem_n[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= base + (push_ok ? LW'(2) : LW'(0));
  end

  assign head = mem[0];
endmodule

// File: rtl/sq_esc_detect.sv
module sq_esc_detect
  import sq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  qstat_e      qs,
  input  logic        taken,
  input  logic [7:0]  head,
  output logic        esc_valid,
  output logic [10:0] esc_opcode
);
  logic       armed;
  logic [2:0] low3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      low3       <= 3'b000;
      esc_valid  <= 1'b0;
      esc_opcode <= '0;
    end else begin
      esc_valid <= 1'b0;
      if (qs == QS_FLUSH) begin
        armed <= 1'b0;
      end else if (taken && qs == QS_FIRST) begin
        armed <= (head[7:3] == ESC_TAG);
        low3  <= head[2:0];
      end else if (taken && qs == QS_NEXT && armed) begin
        armed      <= 1'b0;
        esc_valid  <= 1'b1;
        esc_opcode <= {low3, head};
      end
    end
  end
endmodule

// File: rtl/sq_queue_tracker.sv
module sq_queue_tracker
  import sq_pkg::*;
#(
  parameter int         DEPTH      = 6,
  parameter logic [2:0] FETCH_CODE = 3'b100,
  parameter int         LW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_stat,
  input  logic [15:0]   bus_ad,
  input  logic          bus_dv,
  input  logic [1:0]    qstat,
  output logic          fetch_ready,
  output logic          esc_valid,
  output logic [10:0]   esc_opcode,
  output logic [LW-1:0] q_level,
  output logic          ovf_err,
  output logic          unf_err
);
  qstat_e     qs;
  logic       fetch, pop, flush, taken, drop, under;
  logic [7:0] head;

  assign qs    = qstat_e'(qstat);
  assign fetch = bus_dv && (bus_stat == FETCH_CODE);
  assign pop   = (qs == QS_FIRST) || (qs == QS_NEXT);
  assign flush = (qs == QS_FLUSH);

  sq_shadow_queue #(.DEPTH(DEPTH), .LW(LW)) u_queue (
    .clk(clk), .rst_n(rst_n), .pop(pop), .flush(flush), .push(fetch),
    .push_word(bus_ad), .head(head), .level(q_level), .taken(taken),
    .room(fetch_ready), .push_drop(drop), .pop_under(under)
  );

  sq_esc_detect u_esc (
    .clk(clk), .rst_n(rst_n), .qs(qs), .taken(taken), .head(head),
    .esc_valid(esc_valid), .esc_opcode(esc_opcode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      if (drop)  ovf_err <= 1'b1;
      if (under) unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/sq_tracker_checker.sv
module sq_tracker_checker #(
  parameter int         DEPTH      = 6,
  parameter logic [2:0] FETCH_CODE = 3'b100,
  parameter int         LW         = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_stat,
  input logic          bus_dv,
  input logic [1:0]    qstat,
  input logic          esc_valid,
  input logic [LW-1:0] q_level,
  input logic          ovf_err,
  input logic          unf_err
);
  logic fetch_in;
  assign fetch_in = bus_dv && (bus_stat == FETCH_CODE);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= LW'(DEPTH));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (qstat == 2'b00 && !fetch_in) |=> $stable(q_level));

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (qstat == 2'b10 && !fetch_in) |=> (q_level == '0));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    esc_valid |=> !esc_valid);

  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esc_valid) |-> ($past(qstat) == 2'b11));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);
endmodule

bind sq_queue_tracker sq_tracker_checker #(
  .DEPTH(DEPTH), .FETCH_CODE(FETCH_CODE), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .bus_dv(bus_dv),
  .qstat(qstat), .esc_valid(esc_valid), .q_level(q_level),
  .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/sq_queue_tracker_bench.sv
module sq_queue_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_stat = 3'b000;
  logic [15:0] bus_ad = 16'h0000;
  logic        bus_dv = 1'b0;
  logic [1:0]  qstat = 2'b00;
  logic        fetch_ready, esc_valid, ovf_err, unf_err;
  logic [10:0] esc_opcode;
  logic [2:0]  q_level;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sq_queue_tracker u_sq_queue_tracker (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .bus_ad(bus_ad),
    .bus_dv(bus_dv), .qstat(qstat), .fetch_ready(fetch_ready),
    .esc_valid(esc_valid), .esc_opcode(esc_opcode), .q_level(q_level),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, return at the next falling edge.
  task automatic cyc(logic [1:0] qs, logic dv, logic [2:0] st, logic [15:0] ad);
    qstat = qs; bus_dv = dv; bus_stat = st; bus_ad = ad;
    @(negedge clk);
    qstat = 2'b00; bus_dv = 1'b0; bus_stat = 3'b000; bus_ad = 16'h0000;
  endtask

  task automatic t_reset();
    chk("R1 level", q_level, 0);
    chk("R1 esc_valid", esc_valid, 0);
    chk("R1 ovf", ovf_err, 0);
    chk("R1 unf", unf_err, 0);
    chk("R1 ready", fetch_ready, 1);
  endtask

  task automatic t_escape();
    cyc(2'b00, 1'b1, 3'b100, 16'h2CD9);
    chk("R2 push level", q_level, 2);
    cyc(2'b00, 1'b1, 3'b101, 16'hDBDB);
    chk("R2 non-fetch ignored", q_level, 2);
    cyc(2'b00, 1'b0, 3'b000, 16'h0);
    cyc(2'b00, 1'b0, 3'b000, 16'h0);
    chk("R3 idle level", q_level, 2);
    cyc(2'b01, 1'b0, 3'b000, 16'h0);
    chk("R4 first removed", q_level, 1);
    chk("R4 no pulse yet", esc_valid, 0);
    cyc(2'b11, 1'b0, 3'b000, 16'h0);
    chk("R5 pulse", esc_valid, 1);
    chk("R5 opcode", esc_opcode, 11'h12C);
    chk("R5 level", q_level, 0);
    cyc(2'b00, 1'b0, 3'b000, 16'h0);
    chk("R5 single cycle", esc_valid, 0);
  endtask

  task automatic t_nonesc();
    cyc(2'b00, 1'b1, 3'b100, 16'hDF90);
    cyc(2'b01, 1'b0, 3'b000, 16'h0);
    chk("R4 non-escape no pulse", esc_valid, 0);
    cyc(2'b11, 1'b0, 3'b000, 16'h0);
    chk("R5 unarmed no pulse", esc_valid, 0);
    chk("R5 unarmed byte removed", q_level, 0);
  endtask

  task automatic t_flush();
    cyc(2'b00, 1'b1, 3'b100, 16'h45DB);
    cyc(2'b01, 1'b0, 3'b000, 16'h0);
    cyc(2'b10, 1'b0, 3'b000, 16'h0);
    chk("R6 flush empties", q_level, 0);
    cyc(2'b00, 1'b1, 3'b100, 16'h2211);
    cyc(2'b11, 1'b0, 3'b000, 16'h0);
    chk("R6 escape cancelled", esc_valid, 0);
    cyc(2'b10, 1'b1, 3'b100, 16'h7766);
    chk("R6 flush with fetch", q_level, 2);
    cyc(2'b10, 1'b0, 3'b000, 16'h0);
    chk("R6 flush again", q_level, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 3; i++) cyc(2'b00, 1'b1, 3'b100, 16'h0000);
    chk("R10 full level", q_level, 6);
    chk("R7 ready low when full", fetch_ready, 0);
    chk("R8 no ovf yet", ovf_err, 0);
    cyc(2'b00, 1'b1, 3'b100, 16'h1234);
    chk("R8 ovf set", ovf_err, 1);
    chk("R8 level kept", q_level, 6);
    cyc(2'b01, 1'b0, 3'b000, 16'h0);
    chk("R7 level five", q_level, 5);
    cyc(2'b01, 1'b1, 3'b100, 16'h0000);
    chk("R7 pop then push", q_level, 6);
    chk("R8 ovf sticky", ovf_err, 1);
    cyc(2'b10, 1'b0, 3'b000, 16'h0);
  endtask

  task automatic t_underflow();
    chk("R9 no unf yet", unf_err, 0);
    cyc(2'b11, 1'b0, 3'b000, 16'h0);
    chk("R9 unf set", unf_err, 1);
    chk("R9 level kept", q_level, 0);
    chk("R9 no pulse", esc_valid, 0);
    cyc(2'b00, 1'b0, 3'b000, 16'h0);
    chk("R9 unf sticky", unf_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_escape();
    t_nonesc();
    t_flush();
    t_overflow();
    t_underflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule